// File: doc/BRIEF.md
# SDRAM Clock-Enable Power Mode Tracker

This block observes the clock-enable line and the four command strobes of an SDRAM device on every clock edge and keeps track of the power mode the device is in. The four modes are normal operation, clock suspend, power-down and self-refresh. The block compares the clock-enable value seen on the previous edge with the value on the current edge. It also takes a bank-idle indication from a companion bank state tracker. Together these decide which low-power mode a falling clock-enable selects.

The tracker sits beside a memory controller or a bus monitor. Its mode output qualifies other checkers, for example to mute command checks while the device ignores its pins. Its event pulses mark every entry into and exit from a low-power mode. An error pulse flags a self-refresh exit whose command was not a deselect or a no-operation. A separate pulse counts auto-refresh commands that the device really accepts. All outputs are registered and reflect the inputs sampled on the most recent edge. There is no data stream, so every pin is plain control or status.

Top module: `sdram_pwr_tracker`

## Requirements
- R1: After reset, `pmode` is 0 (normal) and all pulses are low. The stored previous clock-enable starts high, so the first edge after reset can never be read as an exit.
- R2: On an edge where clock-enable was high before and is low now while `banks_idle` is low, `pmode` becomes 1 (clock suspend) and `enter_pulse` is high, whatever the command.
- R3: On such a falling edge with `banks_idle` high and the command {cs_n,ras_n,cas_n,we_n} = 0001 (refresh), `pmode` becomes 3 (self-refresh) and `enter_pulse` is high.
- R4: On such a falling edge with `banks_idle` high and any other command, `pmode` becomes 2 (power-down) and `enter_pulse` is high.
- R5: While clock-enable stays low on two edges in a row, `pmode` is unchanged, no pulse is raised, and the command pins and `banks_idle` have no effect.
- R6: On an edge where clock-enable was low and is now high, in clock suspend or power-down, `pmode` returns to 0 and `exit_pulse` is high with `exit_err` low, whatever the command.
- R7: A rising clock-enable in self-refresh with a deselect (cs_n = 1) or a NOP (0111) returns `pmode` to 0 with `exit_pulse` high and `exit_err` low.
- R8: A rising clock-enable in self-refresh with any other command raises `exit_err` for one cycle together with `exit_pulse`, and `pmode` still returns to 0.
- R9: `refresh_pulse` is high for one cycle only after an edge where clock-enable was high on both that edge and the one before, and the command was 0001.
- R10: `enter_pulse`, `exit_pulse`, `exit_err` and `refresh_pulse` each last one cycle, and `enter_pulse` and `exit_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge sampling |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Observed clock-enable line |
| cs_n | input | 1 | Observed chip select, active low |
| ras_n | input | 1 | Observed row strobe, active low |
| cas_n | input | 1 | Observed column strobe, active low |
| we_n | input | 1 | Observed write enable, active low |
| banks_idle | input | 1 | High when every bank is precharged |
| pmode | output | 2 | 0 normal, 1 suspend, 2 power-down, 3 self-refresh |
| enter_pulse | output | 1 | One-cycle pulse on a low-power entry |
| exit_pulse | output | 1 | One-cycle pulse on a low-power exit |
| exit_err | output | 1 | One-cycle pulse on a malformed self-refresh exit |
| refresh_pulse | output | 1 | One-cycle pulse on an accepted auto-refresh |

## Verification
The assertions assume that `cke` and the command strobes are stable and known at each rising edge. They also assume that `banks_idle` is meaningful only on the edge where clock-enable falls. The stimulus changes every input on the falling clock edge only, so each rising edge sees settled values. The sequences drive each entry kind with deliberately misleading commands, such as a refresh while banks are busy. They also drive each exit with both legal and illegal commands, so the bank state and the exit command are each shown to decide the outcome.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
  localparam int PMODE_W = 2;

  typedef enum logic [PMODE_W-1:0] {
    PM_NORMAL  = 2'd0,
    PM_SUSPEND = 2'd1,
    PM_PDOWN   = 2'd2,
    PM_SELFREF = 2'd3
  } pmode_t;

  typedef enum logic [1:0] {
    CK_DESELECT = 2'd0,
    CK_NOP      = 2'd1,
    CK_REFRESH  = 2'd2,
    CK_OTHER    = 2'd3
  } cmd_kind_t;
endpackage

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify
  import sdram_pwr_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_t kind
);
  logic [2:0] strobes;
  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    if (cs_n)                  kind = CK_DESELECT;
    else if (strobes == 3'b111) kind = CK_NOP;
    else if (strobes == 3'b001) kind = CK_REFRESH;
    else                        kind = CK_OTHER;
  end
endmodule

// File: rtl/sdram_cke_edge.sv
module sdram_cke_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic fell,
  output logic rose,
  output logic held_high
);
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign fell      =  cke_q && !cke;
  assign rose      = !cke_q &&  cke;
  assign held_high =  cke_q &&  cke;
endmodule

// File: rtl/sdram_pmode_fsm.sv
module sdram_pmode_fsm
  import sdram_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fell,
  input  logic      rose,
  input  logic      held_high,
  input  logic      banks_idle,
  input  cmd_kind_t kind,
  output pmode_t    mode,
  output logic      enter_pulse,
  output logic      exit_pulse,
  output logic      exit_err,
  output logic      refresh_pulse
);
  pmode_t mode_d;
  logic   ent_d, ext_d, err_d, ref_d;
  logic   clean_exit;

  assign clean_exit = (kind == CK_DESELECT) || (kind == CK_NOP);

  always_comb begin
    mode_d = mode;
    ent_d  = 1'b0;
    ext_d  = 1'b0;
    err_d  = 1'b0;
    ref_d  = 1'b0;
    if (fell) begin
      ent_d = 1'b1;
      if (!banks_idle)              mode_d = PM_SUSPEND;
      else if (kind == CK_REFRESH)  mode_d = PM_SELFREF;
      else                          mode_d = PM_PDOWN;
    end else if (rose) begin
      ext_d  = 1'b1;
      mode_d = PM_NORMAL;
      if (mode == PM_SELFREF && !clean_exit) err_d = 1'b1;
    end else if (held_high) begin
      ref_d = (kind == CK_REFRESH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode          <= PM_NORMAL;
      enter_pulse   <= 1'b0;
      exit_pulse    <= 1'b0;
      exit_err      <= 1'b0;
      refresh_pulse <= 1'b0;
    end else begin
      mode          <= mode_d;
      enter_pulse   <= ent_d;
      exit_pulse    <= ext_d;
      exit_err      <= err_d;
      refresh_pulse <= ref_d;
    end
  end
endmodule

// File: rtl/sdram_pwr_tracker.sv
module sdram_pwr_tracker
  import sdram_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic               banks_idle,
  output logic [PMODE_W-1:0] pmode,
  output logic               enter_pulse,
  output logic               exit_pulse,
  output logic               exit_err,
  output logic               refresh_pulse
);
  cmd_kind_t kind;
  pmode_t    mode;
  logic      fell, rose, held_high;

  sdram_cmd_classify u_cls (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(kind)
  );

  sdram_cke_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .fell(fell), .rose(rose), .held_high(held_high)
  );

  sdram_pmode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fell(fell), .rose(rose),
    .held_high(held_high), .banks_idle(banks_idle), .kind(kind),
    .mode(mode), .enter_pulse(enter_pulse), .exit_pulse(exit_pulse),
    .exit_err(exit_err), .refresh_pulse(refresh_pulse)
  );

  assign pmode = mode;
endmodule

// File: rtl/sdram_pwr_tracker_chk.sv
module sdram_pwr_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       banks_idle,
  input logic [1:0] pmode,
  input logic       enter_pulse,
  input logic       exit_pulse,
  input logic       exit_err,
  input logic       refresh_pulse
);
  logic       seen_q;
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b1;
    else        seen_q <= cke;
  end

  p_suspend_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !cke && !banks_idle) |=> (pmode == 2'd1 && enter_pulse));

  p_selfref_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !cke && banks_idle && cmd == 4'b0001) |=> (pmode == 2'd3 && enter_pulse));

  p_pdown_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !cke && banks_idle && cmd != 4'b0001) |=> (pmode == 2'd2 && enter_pulse));

  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !cke) |=> ($stable(pmode) && !enter_pulse && !exit_pulse));

  p_exit_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && cke) |=> (pmode == 2'd0 && exit_pulse));

  p_err_with_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_err |-> exit_pulse);

  p_refresh_needs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> (pmode == 2'd0 && seen_q));

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_pulse, exit_pulse}));
endmodule

bind sdram_pwr_tracker sdram_pwr_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle), .pmode(pmode),
  .enter_pulse(enter_pulse), .exit_pulse(exit_pulse), .exit_err(exit_err),
  .refresh_pulse(refresh_pulse)
);

// File: tb/sdram_pwr_tracker_tb.sv
`timescale 1ns/1ps
module sdram_pwr_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic banks_idle = 1'b1;
  logic [1:0] pmode;
  logic enter_pulse, exit_pulse, exit_err, refresh_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // model state
  int  m_prev = 1;
  int  m_mode = 0;
  bit  m_ent = 0, m_ext = 0, m_err = 0, m_ref = 0;

  localparam logic [3:0] C_NOP = 4'b0111, C_REF = 4'b0001, C_DESL = 4'b1000,
                         C_ACT = 4'b0011, C_READ = 4'b0101;

  always #10 clk = ~clk;

  sdram_pwr_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle), .pmode(pmode),
    .enter_pulse(enter_pulse), .exit_pulse(exit_pulse), .exit_err(exit_err),
    .refresh_pulse(refresh_pulse)
  );

  task automatic compare(input string req);
    logic [5:0] act, exp;
    act = {pmode, enter_pulse, exit_pulse, exit_err, refresh_pulse};
    exp = {m_mode[1:0], m_ent, m_ext, m_err, m_ref};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {mode,ent,ext,err,ref} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input logic [3:0] cmd, input bit idle, input string req);
    bit refcmd, clean;
    @(negedge clk);
    cke = c; {cs_n, ras_n, cas_n, we_n} = cmd; banks_idle = idle;
    @(posedge clk);
    refcmd = (cmd == C_REF);
    clean  = cmd[3] || (cmd == C_NOP);
    m_ent = 0; m_ext = 0; m_err = 0; m_ref = 0;
    if (m_prev == 1 && !c) begin
      m_ent = 1;
      m_mode = !idle ? 1 : (refcmd ? 3 : 2);
    end else if (m_prev == 0 && c) begin
      m_ext = 1;
      if (m_mode == 3 && !clean) m_err = 1;
      m_mode = 0;
    end else if (m_prev == 1 && c) begin
      m_ref = refcmd;
    end
    m_prev = c;
    #2;
    compare(req);
  endtask

  initial begin
    #(20 * 2000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #35;
    #2 compare("R1");
    rst_n = 1'b1;
    cyc(1, C_NOP, 1, "R1");
    cyc(1, C_NOP, 1, "R1");
    // suspend entry with busy banks, even with a refresh command
    cyc(0, C_REF, 0, "R2");
    cyc(0, C_ACT, 1, "R5");
    cyc(0, C_REF, 1, "R5");
    cyc(1, C_READ, 0, "R6");
    cyc(1, C_NOP, 0, "R10");
    // self-refresh entry and clean NOP exit
    cyc(0, C_REF, 1, "R3");
    cyc(0, C_ACT, 0, "R5");
    cyc(0, C_NOP, 1, "R5");
    cyc(1, C_NOP, 1, "R7");
    cyc(1, C_NOP, 1, "R10");
    // self-refresh with deselect exit
    cyc(0, C_REF, 1, "R3");
    cyc(1, C_DESL, 1, "R7");
    // self-refresh with malformed exit
    cyc(0, C_REF, 1, "R3");
    cyc(0, C_REF, 1, "R5");
    cyc(1, C_ACT, 1, "R8");
    cyc(1, C_NOP, 1, "R8");
    // power-down entry, exit carrying refresh command
    cyc(0, C_NOP, 1, "R4");
    cyc(0, C_REF, 1, "R5");
    cyc(1, C_REF, 1, "R6");
    cyc(1, C_REF, 1, "R9");
    cyc(1, C_REF, 1, "R9");
    cyc(1, C_NOP, 1, "R10");
    cyc(0, C_DESL, 1, "R4");
    cyc(1, C_ACT, 1, "R6");
    cyc(1, {1'b1, 3'b001}, 1, "R9");
    // refresh while cke falls is entry, not a counted refresh
    cyc(0, C_REF, 1, "R9");
    cyc(1, C_DESL, 1, "R7");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule